// File: doc/BRIEF.md
# Configurable Interrupt Priority Selector

This block holds a pending flag for each of eight peripheral interrupt sources and decides which pending source is offered to the acceptance sequencer. The sources are a key-scan input, two external pins, three timers, a watchdog and a basic interval timer. A small control register sets the arbitration policy. Its 2-bit policy field picks one of three behaviours. Policy 00 ranks the sources in a fixed hardware order. Policy 01 lets software promote one source, named by a 4-bit select field, above all the others. Policy 1x refuses every grant.

A grant is offered only while the master interrupt enable is high. When the sequencer acknowledges a grant, the block pulses a one-hot clear strobe for the granted source, and that source's pending flag drops on the next clock edge. Software can also drop pending flags directly through a clear vector. A request that arrives in the same cycle as a clear of its own flag wins, so the flag stays set.

Top module: `irq_prio_sel`

## Requirements
- R1: After reset, every pending flag is 0, `reg_rdata` reads 0x00, and `grant_valid` stays low even with `master_en` high.
- R2: A request pulse sets the source's pending flag. The flag stays set, and the source keeps being offered, until it is acknowledged or cleared by software.
- R3: Source index order is key-scan 0, external-1 1, external-2 2, timer-0 3, timer-1 4, timer-2 5, watchdog 6, interval-timer 7. With policy 00, `grant_idx` is the lowest pending index.
- R4: With policy 01, the select codes 1, 2, 3, 5, 6, 7, 10, 11 name indices 0 to 7 in that order. The named source is granted whenever it is pending.
- R5: With policy 01, if the select code names no source, or the named source is not pending, the fixed order of R3 applies.
- R6: With policy 10 or 11, `grant_valid` is never asserted.
- R7: `grant_valid` is 1 exactly when `master_en` is 1, policy bit 5 is 0, and at least one flag is pending.
- R8: In a cycle where `grant_ack` and `grant_valid` are both 1, `clr_strobe` is one-hot at `grant_idx` and the flag clears at the next edge. Otherwise `clr_strobe` is 0.
- R9: `reg_wdata` bits 5:4 (policy) and 3:0 (select) are stored on `reg_wr`. Bits 7:6 ignore writes and read 0. The stored value is visible on `reg_rdata` from the following cycle.
- R10: A request and a clear (acknowledge or software) for the same source in the same cycle leave its flag set.
- R11: A 1 in bit i of `irq_clr` clears pending flag i at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 8 | Per-source request pulses |
| irq_clr | input | 8 | Software clear of pending flags |
| master_en | input | 1 | Master enable for maskable grants |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| grant_valid | output | 1 | A source is offered for acceptance |
| grant_idx | output | 3 | Index of the offered source |
| grant_ack | input | 1 | Sequencer accepts the offered source |
| clr_strobe | output | 8 | One-hot clear of the accepted source |

## Verification
The assertions assume all inputs are known after the internal reset release. They also assume that `grant_ack` is judged against the same-cycle `grant_valid`. An acknowledge with no valid grant is legal and must leave everything unchanged. The random stimulus drives every input from known values at the falling edge. It issues acknowledges freely, including in cycles with no grant. It rewrites the control register often enough to visit all four policies, and both matching and non-matching select codes.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;

  localparam int NUM_SRC = 8;
  localparam int SEL_W   = 4;
  localparam int MODE_W  = 2;
  localparam int REG_W   = 8;

  typedef enum logic [MODE_W-1:0] {
    POL_FIXED = 2'b00,
    POL_PROG  = 2'b01,
    POL_OFF_A = 2'b10,
    POL_OFF_B = 2'b11
  } prio_pol_e;

  // select code that names source idx; 0 for indices without a code
  function automatic logic [SEL_W-1:0] src_code(input int unsigned idx);
    logic [SEL_W-1:0] c;
    case (idx)
      0: c = 4'd1;
      1: c = 4'd2;
      2: c = 4'd3;
      3: c = 4'd5;
      4: c = 4'd6;
      5: c = 4'd7;
      6: c = 4'd10;
      7: c = 4'd11;
      default: c = 4'd0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/irq_latch_bank.sv
`timescale 1ns/1ps
module irq_latch_bank #(
  parameter int N = irq_prio_pkg::NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);

  logic [N-1:0] pend_nxt;
  logic         pend_en;

  // set dominates clear
  always_comb begin
    pend_en  = (|req) | (|clr);
    pend_nxt = (pend & ~clr) | req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= '0;
    else if (pend_en) pend <= pend_nxt;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R2: an uncleared flag holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && !clr[i]) |=> pend[i]);
    // R10: a request always leaves the flag set
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      req[i] |=> pend[i]);
    // R11: a clear without a request drops the flag
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !req[i]) |=> !pend[i]);
  end

endmodule

// File: rtl/irq_mode_reg.sv
`timescale 1ns/1ps
module irq_mode_reg
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output prio_pol_e        pol,
  output logic [SEL_W-1:0] sel,
  output logic [REG_W-1:0] rdata
);

  localparam int PAD_W = REG_W - MODE_W - SEL_W;

  prio_pol_e        pol_nxt;
  logic [SEL_W-1:0] sel_nxt;

  always_comb begin
    pol_nxt = prio_pol_e'(wdata[SEL_W +: MODE_W]);
    sel_nxt = wdata[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol <= POL_FIXED;
      sel <= '0;
    end else if (wr) begin
      pol <= pol_nxt;
      sel <= sel_nxt;
    end
  end

  always_comb rdata = {{PAD_W{1'b0}}, pol, sel};

  // R9: a write lands on the read port the next cycle
  a_r9_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> rdata[MODE_W+SEL_W-1:0] == $past(wdata[MODE_W+SEL_W-1:0]));
  // R9: no write, no change
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(rdata));

endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter  int N     = NUM_SRC,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     pend,
  input  prio_pol_e        pol,
  input  logic [SEL_W-1:0] sel,
  input  logic             master_en,
  input  logic             ack,
  output logic             grant_valid,
  output logic [IDX_W-1:0] grant_idx,
  output logic [N-1:0]     clr_strobe
);

  logic [IDX_W-1:0] fix_idx;
  logic [IDX_W-1:0] hit_idx;
  logic             hit;
  logic             allow;

  // lowest pending index
  always_comb begin
    fix_idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (pend[i]) fix_idx = IDX_W'(i);
    end
  end

  // software-named source, if pending
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && (src_code(i) == sel) && (src_code(i) != '0)) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    allow       = master_en && (pol == POL_FIXED || pol == POL_PROG);
    grant_valid = allow && (|pend);
    grant_idx   = (pol == POL_PROG && hit) ? hit_idx : fix_idx;
    clr_strobe  = '0;
    if (ack && grant_valid) clr_strobe[grant_idx] = 1'b1;
  end

  // R7: a grant needs the enable and a pending flag
  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (master_en && (|pend) && pend[grant_idx]));
  // R6: blocking policies never grant
  a_r6_off: assert property (@(posedge clk) disable iff (!rst_n)
    pol[1] |-> !grant_valid);
  // R3: fixed policy grants the lowest pending index
  a_r3_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && pol == POL_FIXED) |->
      ((pend & ((N'(1) << grant_idx) - N'(1))) == '0));
  // R8: the clear strobe is one-hot and only on acceptance
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_strobe));
  a_r8_only_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_strobe) |-> (ack && grant_valid));

endmodule

// File: rtl/irq_prio_sel.sv
`timescale 1ns/1ps
module irq_prio_sel
  import irq_prio_pkg::*;
#(
  parameter  int N     = NUM_SRC,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irq_req,
  input  logic [N-1:0]     irq_clr,
  input  logic             master_en,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             grant_valid,
  output logic [IDX_W-1:0] grant_idx,
  input  logic             grant_ack,
  output logic [N-1:0]     clr_strobe
);

  logic [1:0]       rst_sync;
  logic             srst_n;
  logic [N-1:0]     pend;
  logic [N-1:0]     clr_all;
  prio_pol_e        pol;
  logic [SEL_W-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  assign clr_all = irq_clr | clr_strobe;

  irq_latch_bank #(.N(N)) u_latch (
    .clk  (clk),
    .rst_n(srst_n),
    .req  (irq_req),
    .clr  (clr_all),
    .pend (pend)
  );

  irq_mode_reg u_reg (
    .clk  (clk),
    .rst_n(srst_n),
    .wr   (reg_wr),
    .wdata(reg_wdata),
    .pol  (pol),
    .sel  (sel),
    .rdata(reg_rdata)
  );

  irq_arbiter #(.N(N)) u_arb (
    .clk        (clk),
    .rst_n      (srst_n),
    .pend       (pend),
    .pol        (pol),
    .sel        (sel),
    .master_en  (master_en),
    .ack        (grant_ack),
    .grant_valid(grant_valid),
    .grant_idx  (grant_idx),
    .clr_strobe (clr_strobe)
  );

  // R8: an accepted source is gone next cycle unless re-requested
  a_r8_cleared: assert property (@(posedge clk) disable iff (!srst_n)
    (grant_valid && grant_ack && !irq_req[grant_idx] && !$isunknown(grant_idx))
      |=> !pend[$past(grant_idx)]);

endmodule

// File: tb/test_irq_prio_sel.sv
`timescale 1ns/1ps
module test_irq_prio_sel;

  localparam int N = 8;

  logic       clk;
  logic       rst_n;
  logic [7:0] irq_req, irq_clr, reg_wdata, reg_rdata, clr_strobe;
  logic       master_en, reg_wr, grant_valid, grant_ack;
  logic [2:0] grant_idx;

  logic [7:0] m_pend;
  logic [1:0] m_mode;
  logic [3:0] m_sel;
  int n_chk, n_fail;
  bit done;

  irq_prio_sel i_irq_prio_sel (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_clr(irq_clr),
    .master_en(master_en), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .grant_valid(grant_valid), .grant_idx(grant_idx),
    .grant_ack(grant_ack), .clr_strobe(clr_strobe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int code_to_idx(input logic [3:0] c);
    case (c)
      4'd1: return 0;   4'd2: return 1;  4'd3: return 2;  4'd5: return 3;
      4'd6: return 4;   4'd7: return 5;  4'd10: return 6; 4'd11: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic int low_idx(input logic [7:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return i;
    return 0;
  endfunction

  function automatic int exp_idx(input logic [7:0] p, input logic [1:0] m, input logic [3:0] s);
    int ci = code_to_idx(s);
    if (m == 2'b01 && ci >= 0 && p[ci]) return ci;
    return low_idx(p);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle, check the outputs, advance the model
  task automatic step(input logic [7:0] req, input logic [7:0] clr, input logic en,
                      input logic ack, input logic wr, input logic [7:0] wd,
                      input string ctx);
    bit ev;
    int ei;
    logic [7:0] es;
    string gtag;
    @(negedge clk);
    irq_req = req; irq_clr = clr; master_en = en; grant_ack = ack;
    reg_wr = wr; reg_wdata = wd;
    #2;
    ev = en && !m_mode[1] && (m_pend != 0);
    ei = exp_idx(m_pend, m_mode, m_sel);
    es = (ack && ev) ? (8'd1 << ei) : 8'd0;
    if (ctx != "")          gtag = ctx;
    else if (m_mode[1])     gtag = "R6";
    else if (!en)           gtag = "R7";
    else if (m_mode == 2'b01) gtag = (code_to_idx(m_sel) >= 0 && m_pend[code_to_idx(m_sel)]) ? "R4" : "R5";
    else                    gtag = "R3";
    check({gtag, " grant_valid"}, grant_valid, ev);
    if (ev) check({gtag, " grant_idx"}, grant_idx, ei);
    check("R8 clr_strobe", clr_strobe, es);
    check("R9 reg_rdata", reg_rdata, {2'b00, m_mode, m_sel});
    m_pend = (m_pend & ~(clr | es)) | req;
    if (wr) begin m_mode = wd[5:4]; m_sel = wd[3:0]; end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rq, cl, wd;
    void'($urandom(32'd4711));
    n_chk = 0; n_fail = 0; done = 0;
    m_pend = '0; m_mode = '0; m_sel = '0;
    irq_req = '0; irq_clr = '0; master_en = 0; grant_ack = 0; reg_wr = 0; reg_wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    step(8'h00, 8'h00, 1, 0, 0, 8'h00, "R1");
    check("R1 reset rdata", reg_rdata, 0);

    // R9: unused bits ignore writes
    step(8'h00, 8'h00, 1, 0, 1, 8'hC0, "");
    step(8'h00, 8'h00, 1, 0, 0, 8'h00, "R9");
    check("R9 unused bits", reg_rdata, 8'h00);

    // R2: request held with no acknowledge
    step(8'h20, 8'h00, 1, 0, 0, 8'h00, "");
    for (int k = 0; k < 4; k++) step(8'h00, 8'h00, 1, 0, 0, 8'h00, "R2");
    // R3: lower index overtakes
    step(8'h02, 8'h00, 1, 0, 0, 8'h00, "");
    step(8'h00, 8'h00, 1, 1, 0, 8'h00, "R3");
    step(8'h00, 8'h00, 1, 0, 0, 8'h00, "R8");
    // R4: promote watchdog (code 10)
    step(8'h40, 8'h00, 1, 0, 1, 8'h1A, "");
    step(8'h00, 8'h00, 1, 0, 0, 8'h00, "R4");
    check("R4 watchdog promoted", grant_idx, 6);
    // R5: unmatched code 4 falls back to fixed
    step(8'h00, 8'h00, 1, 0, 1, 8'h14, "");
    step(8'h00, 8'h00, 1, 0, 0, 8'h00, "R5");
    // R10: acknowledge and new request on the same source
    step(8'h20, 8'h00, 1, 1, 1, 8'h00, "R10");
    step(8'h00, 8'h00, 1, 0, 0, 8'h00, "R10");
    check("R10 flag kept", grant_idx, 5);
    // R11: software clear empties the bank
    step(8'h00, 8'hFF, 1, 0, 0, 8'h00, "R11");
    step(8'h00, 8'h00, 1, 0, 0, 8'h00, "R11");
    check("R11 nothing pending", grant_valid, 0);
    // R6: blocked policy
    step(8'h81, 8'h00, 1, 0, 1, 8'h20, "");
    step(8'h00, 8'h00, 1, 1, 0, 8'h00, "R6");
    step(8'h00, 8'h00, 1, 0, 1, 8'h00, "");
    step(8'h00, 8'h00, 0, 1, 0, 8'h00, "R7");

    for (int k = 0; k < 4000; k++) begin
      rq = '0; cl = '0;
      for (int b = 0; b < N; b++) begin
        if ($urandom_range(7) == 0) rq[b] = 1'b1;
        if ($urandom_range(31) == 0) cl[b] = 1'b1;
      end
      wd = 8'($urandom);
      step(rq, cl, $urandom_range(7) != 0, $urandom_range(1) == 1,
           $urandom_range(15) == 0, wd, "");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule